// File: doc/BRIEF.md
# Power State Soft-Reset Controller

This block keeps track of the device power state that software selects through a two-bit power-state field. It decides whether a software move from D3hot back to D0 wipes the configuration context. A no-soft-reset option bit is captured from the configuration word that the power-up loader delivers. When that bit is clear, the wake-up write starts an internal reset pulse of fixed length. When it is set, the device returns to D0 with its context intact.

The block also drives an "initialized" status flag. The flag drops whenever the context is lost and rises again only after software has re-programmed the device and signalled that it is done. A synchronous system reset always returns the device to D0 uninitialized. The PME enable and PME status bits survive that reset only when PME is implemented, supported and enabled. A soft reset leaves them untouched.

Top module: `pss_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `pmc_img` reads 0, `soft_rst_o` is 0 and `dev_init` is 0.
- R2: The power-state encoding is 2'b00 = D0, 2'b01 = D1, 2'b10 = D2 and 2'b11 = D3hot. A write strobe `ps_wr` with `ps_wdata` updates the state, and the new state is visible on `pmc_img[1:0]` in the cycle after the strobe.
- R3: A write of D0 while the state is D3hot, with the no-soft-reset bit clear, raises `soft_rst_o` from the next cycle for exactly SRST_CYC cycles (default 4). `dev_init` is 0 from that same cycle.
- R4: The same D3hot-to-D0 write with the no-soft-reset bit set gives no pulse. The state becomes D0 and `dev_init` keeps its value.
- R5: No other write makes a pulse. This covers D0 to D3hot, D3hot to D3hot, D3hot to D1 or D2, and any move among D0, D1 and D2.
- R6: `dev_init` rises in the cycle after `init_done` only when the state is D0 and no pulse is active. An `init_done` in D1, D2 or D3hot, or during the pulse, is ignored.
- R7: Power-state writes that arrive while `soft_rst_o` is high are ignored.
- R8: A cycle with `sys_rst` high leaves, in the next cycle, the state at D0, `dev_init` at 0 and any pulse cancelled, whatever the no-soft-reset bit is. The no-soft-reset bit itself is kept.
- R9: The PME enable (`pmc_img[2]`) can be set only while `pme_cap` is 1. The PME status (`pmc_img[4]`) is set by `pme_sts_set` only while `pme_cap` is 1 and is cleared by `pme_sts_clr`. On `sys_rst`, both bits are kept if `pme_cap` and PME enable are both 1, and are cleared otherwise.
- R10: On `cfg_ld_valid`, the no-soft-reset bit is loaded from `cfg_ld_word[NSR_SRC_BIT]` (default bit 14). It reads back on `pmc_img[3]`, and no other bit of the word affects it.
- R11: `pmc_img` layout: bits [1:0] hold the state, bit 2 the PME enable, bit 3 the no-soft-reset bit and bit 4 the PME status. Bits [7:5] read 0.
- R12: A soft reset leaves the PME enable and PME status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system / bus-segment reset, active high |
| cfg_ld_valid | input | 1 | Power-up loader delivers the configuration word |
| cfg_ld_word | input | CFG_W | Configuration word from the loader |
| ps_wr | input | 1 | Software write strobe for the power-state field |
| ps_wdata | input | 2 | Power-state value being written |
| init_done | input | 1 | Software has finished re-programming the device |
| pme_cap | input | 1 | PME is supported |
| pme_en_wr | input | 1 | Write strobe for the PME enable |
| pme_en_wdata | input | 1 | PME enable value being written |
| pme_sts_set | input | 1 | PME event sets the PME status |
| pme_sts_clr | input | 1 | Software clears the PME status |
| pmc_img | output | 8 | Power-management control image |
| soft_rst_o | output | 1 | Internal soft-reset pulse |
| dev_init | output | 1 | Device is in D0 initialized |

## Verification
The bench drives both wake-up paths and counts the pulse cycle by cycle. A counter off by one, or a pulse that is never gated, shows up as a width other than four. While the pulse is active, the bench also sends a power-state write and an `init_done`. A design that lets either through would leave the state in D3hot or report the device initialized before software has re-programmed it.

The bench asserts a system reset in the middle of a pulse and with the no-soft-reset bit set. This catches designs that let the pulse run on, or that keep the device initialized. It also checks PME context across system resets with and without the enable, and across a soft reset, which exposes designs that clear it unconditionally or never clear it.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic [1:0] {
      PS_D0    = 2'b00,
      PS_D1    = 2'b01,
      PS_D2    = 2'b10,
      PS_D3HOT = 2'b11
   } pwr_state_e;

   localparam int PMC_W       = 8;
   localparam int PMC_PS_LSB  = 0;
   localparam int PMC_PME_EN  = 2;
   localparam int PMC_NSR     = 3;
   localparam int PMC_PME_STS = 4;

endpackage

// File: rtl/pss_cfg_latch.sv
module pss_cfg_latch #(
   parameter int CFG_W   = 16,
   parameter int SRC_BIT = 14
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ld_valid,
   input  logic [CFG_W-1:0] ld_word,
   output logic             nsr
);

   localparam int LAST_BIT = CFG_W - 1;

   if (SRC_BIT > LAST_BIT || SRC_BIT < 0) begin : g_bad_src
      $error("pss_cfg_latch: SRC_BIT outside configuration word");
   end

   logic word_unused;
   assign word_unused = ^ld_word;

   // only power-on clears the option; system reset keeps it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         nsr <= 1'b0;
      else if (ld_valid)
         nsr <= ld_word[SRC_BIT];
   end

endmodule

// File: rtl/pss_rst_pulse.sv
module pss_rst_pulse #(
   parameter int SRST_CYC = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst,
   input  logic fire,
   output logic busy
);

   localparam int CNT_W = (SRST_CYC < 2) ? 1 : $clog2(SRST_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYC);

   if (SRST_CYC < 1) begin : g_bad_len
      $error("pss_rst_pulse: SRST_CYC must be at least 1");
   end

   if (SRST_CYC == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            q <= 1'b0;
         else if (sys_rst)
            q <= 1'b0;
         else
            q <= fire;
      end
      assign busy = q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            cnt <= '0;
         else if (sys_rst)
            cnt <= '0;
         else if (fire)
            cnt <= CNT_LOAD;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
   end

endmodule

// File: rtl/pss_state_trk.sv
module pss_state_trk
   import pss_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst,
   input  logic       ps_wr,
   input  logic [1:0] ps_wdata,
   input  logic       nsr,
   input  logic       pulse_busy,
   input  logic       init_done,
   output pwr_state_e state,
   output logic       fire,
   output logic       dev_init
);

   logic       wr_ok;
   logic       wake;
   pwr_state_e nxt;

   assign nxt   = pwr_state_e'(ps_wdata);
   assign wr_ok = ps_wr & ~pulse_busy;
   assign wake  = wr_ok & (state == PS_D3HOT) & (nxt == PS_D0);
   assign fire  = wake & ~nsr;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         state <= PS_D0;
      else if (sys_rst)
         state <= PS_D0;
      else if (wr_ok)
         state <= nxt;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         dev_init <= 1'b0;
      else if (sys_rst || fire)
         dev_init <= 1'b0;
      else if (init_done && !pulse_busy && state == PS_D0)
         dev_init <= 1'b1;
   end

endmodule

// File: rtl/pss_pme_ctx.sv
module pss_pme_ctx #(
   parameter bit PME_IMPL = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst,
   input  logic pme_cap,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic sts_set,
   input  logic sts_clr,
   output logic pme_en,
   output logic pme_sts
);

   if (PME_IMPL) begin : g_pme
      logic keep_ctx;
      assign keep_ctx = pme_cap & pme_en;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            pme_en <= 1'b0;
         else if (sys_rst)
            pme_en <= keep_ctx ? pme_en : 1'b0;
         else if (en_wr)
            pme_en <= en_wdata & pme_cap;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            pme_sts <= 1'b0;
         else if (sys_rst)
            pme_sts <= keep_ctx ? pme_sts : 1'b0;
         else if (sts_set && pme_cap)
            pme_sts <= 1'b1;
         else if (sts_clr)
            pme_sts <= 1'b0;
      end
   end else begin : g_no_pme
      logic pme_unused;
      assign pme_unused = ^{clk, por_n, sys_rst, pme_cap, en_wr, en_wdata, sts_set, sts_clr};
      assign pme_en  = 1'b0;
      assign pme_sts = 1'b0;
   end

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
   import pss_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int NSR_SRC_BIT = 14,
   parameter int SRST_CYC    = 4,
   parameter bit PME_IMPL    = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst,
   input  logic             cfg_ld_valid,
   input  logic [CFG_W-1:0] cfg_ld_word,
   input  logic             ps_wr,
   input  logic [1:0]       ps_wdata,
   input  logic             init_done,
   input  logic             pme_cap,
   input  logic             pme_en_wr,
   input  logic             pme_en_wdata,
   input  logic             pme_sts_set,
   input  logic             pme_sts_clr,
   output logic [7:0]       pmc_img,
   output logic             soft_rst_o,
   output logic             dev_init
);

   if (CFG_W < 1) begin : g_bad_cfg
      $error("pss_ctrl: CFG_W must be positive");
   end

   logic       nsr_q;
   logic       fire;
   logic       busy;
   logic       pme_en_q;
   logic       pme_sts_q;
   pwr_state_e state_q;

   pss_cfg_latch #(
      .CFG_W   (CFG_W),
      .SRC_BIT (NSR_SRC_BIT)
   ) u_cfg (
      .clk      (clk),
      .por_n    (por_n),
      .ld_valid (cfg_ld_valid),
      .ld_word  (cfg_ld_word),
      .nsr      (nsr_q)
   );

   pss_state_trk u_trk (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst    (sys_rst),
      .ps_wr      (ps_wr),
      .ps_wdata   (ps_wdata),
      .nsr        (nsr_q),
      .pulse_busy (busy),
      .init_done  (init_done),
      .state      (state_q),
      .fire       (fire),
      .dev_init   (dev_init)
   );

   pss_rst_pulse #(
      .SRST_CYC (SRST_CYC)
   ) u_pulse (
      .clk     (clk),
      .por_n   (por_n),
      .sys_rst (sys_rst),
      .fire    (fire),
      .busy    (busy)
   );

   pss_pme_ctx #(
      .PME_IMPL (PME_IMPL)
   ) u_pme (
      .clk      (clk),
      .por_n    (por_n),
      .sys_rst  (sys_rst),
      .pme_cap  (pme_cap),
      .en_wr    (pme_en_wr),
      .en_wdata (pme_en_wdata),
      .sts_set  (pme_sts_set),
      .sts_clr  (pme_sts_clr),
      .pme_en   (pme_en_q),
      .pme_sts  (pme_sts_q)
   );

   assign soft_rst_o = busy;

   always_comb begin
      pmc_img = '0;
      pmc_img[PMC_PS_LSB +: 2] = state_q;
      pmc_img[PMC_PME_EN]      = pme_en_q;
      pmc_img[PMC_NSR]         = nsr_q;
      pmc_img[PMC_PME_STS]     = pme_sts_q;
   end

endmodule

// File: rtl/pss_ctrl_chk.sv
module pss_ctrl_chk #(
   parameter int SRST_CYC = 4
) (
   input logic       clk,
   input logic       por_n,
   input logic       sys_rst,
   input logic       ps_wr,
   input logic [1:0] ps_wdata,
   input logic       nsr,
   input logic [1:0] state,
   input logic       soft_rst_o,
   input logic       dev_init,
   input logic       pme_en,
   input logic       pme_sts
);

   localparam int RUN_W = $clog2(SRST_CYC + 2) + 1;

   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         run <= '0;
      else if (soft_rst_o)
         run <= run + 1'b1;
      else
         run <= '0;
   end

   // R3
   wake_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ps_wr && !soft_rst_o && !sys_rst && state == 2'b11 && ps_wdata == 2'b00 && !nsr)
      |=> (soft_rst_o && !dev_init && state == 2'b00));

   // R3
   pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(soft_rst_o) && !$past(sys_rst)) |-> (run == RUN_W'(SRST_CYC)));

   // R4
   wake_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (ps_wr && !soft_rst_o && !sys_rst && state == 2'b11 && ps_wdata == 2'b00 && nsr)
      |=> (!soft_rst_o && state == 2'b00 && dev_init == $past(dev_init)));

   // R5
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(soft_rst_o) |-> ($past(ps_wr) && $past(state) == 2'b11 &&
                             $past(ps_wdata) == 2'b00 && !$past(nsr)));

   // R6
   init_low_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst_o |-> !dev_init);

   // R7
   wr_block_chk: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_o && !sys_rst) |=> $stable(state));

   // R8
   sys_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst |=> (state == 2'b00 && !dev_init && !soft_rst_o && $stable(nsr)));

   // R9
   pme_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst && pme_en) |=> (pme_en || !$past(pme_en)));

   // R9
   pme_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sys_rst && !pme_en) |=> !pme_sts);

endmodule

bind pss_ctrl pss_ctrl_chk #(.SRST_CYC(SRST_CYC)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .sys_rst    (sys_rst),
   .ps_wr      (ps_wr),
   .ps_wdata   (ps_wdata),
   .nsr        (nsr_q),
   .state      (pmc_img[1:0]),
   .soft_rst_o (soft_rst_o),
   .dev_init   (dev_init),
   .pme_en     (pme_en_q),
   .pme_sts    (pme_sts_q)
);

// File: tb/test_pss_ctrl.sv
`timescale 1ns/1ps
module test_pss_ctrl;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst = 1'b0;
   logic        cfg_ld_valid = 1'b0;
   logic [15:0] cfg_ld_word = '0;
   logic        ps_wr = 1'b0;
   logic [1:0]  ps_wdata = '0;
   logic        init_done = 1'b0;
   logic        pme_cap = 1'b0;
   logic        pme_en_wr = 1'b0;
   logic        pme_en_wdata = 1'b0;
   logic        pme_sts_set = 1'b0;
   logic        pme_sts_clr = 1'b0;
   logic [7:0]  pmc_img;
   logic        soft_rst_o;
   logic        dev_init;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pss_ctrl i_pss_ctrl (
      .clk          (clk),
      .por_n        (por_n),
      .sys_rst      (sys_rst),
      .cfg_ld_valid (cfg_ld_valid),
      .cfg_ld_word  (cfg_ld_word),
      .ps_wr        (ps_wr),
      .ps_wdata     (ps_wdata),
      .init_done    (init_done),
      .pme_cap      (pme_cap),
      .pme_en_wr    (pme_en_wr),
      .pme_en_wdata (pme_en_wdata),
      .pme_sts_set  (pme_sts_set),
      .pme_sts_clr  (pme_sts_clr),
      .pmc_img      (pmc_img),
      .soft_rst_o   (soft_rst_o),
      .dev_init     (dev_init)
   );

   // vector: {ps_wr, ps_wdata[1:0], init_done, exp_state[1:0], exp_init, exp_srst}
   localparam int NVEC = 11;
   localparam logic [7:0] VEC [NVEC] = '{
      8'b0_00_1_00_1_0,  // init_done in D0
      8'b1_11_0_11_1_0,  // D0 -> D3hot
      8'b0_00_1_11_1_0,  // init_done in D3hot ignored
      8'b1_00_0_00_1_0,  // D3hot -> D0, context kept
      8'b1_01_0_01_1_0,  // D0 -> D1
      8'b1_10_0_10_1_0,  // D1 -> D2
      8'b1_01_0_01_1_0,  // D2 -> D1
      8'b1_11_0_11_1_0,  // D1 -> D3hot
      8'b1_01_0_01_1_0,  // D3hot -> D1
      8'b1_00_0_00_1_0,  // D1 -> D0
      8'b0_00_0_00_1_0   // idle
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_ps(input logic [1:0] v);
      ps_wr = 1'b1; ps_wdata = v;
      tick();
      ps_wr = 1'b0;
   endtask

   task automatic load_cfg(input logic [15:0] w);
      cfg_ld_valid = 1'b1; cfg_ld_word = w;
      tick();
      cfg_ld_valid = 1'b0;
   endtask

   task automatic pulse_init();
      init_done = 1'b1;
      tick();
      init_done = 1'b0;
   endtask

   task automatic pulse_sys();
      sys_rst = 1'b1;
      tick();
      sys_rst = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int plen;
      repeat (3) tick();
      // R1 reset state
      chk("R1 pmc", pmc_img, 8'h00);
      chk("R1 srst", soft_rst_o, 1'b0);
      chk("R1 init", dev_init, 1'b0);
      por_n = 1'b1;
      tick();
      chk("R1 pmc after release", pmc_img, 8'h00);

      // R10 only the source bit counts
      load_cfg(16'hBFFF);
      chk("R10 other bits", pmc_img[3], 1'b0);
      load_cfg(16'h4000);
      chk("R10 bit 14", pmc_img[3], 1'b1);

      // R2 R4 R5 R6 table with no-soft-reset set
      for (int i = 0; i < NVEC; i++) begin
         ps_wr     = VEC[i][7];
         ps_wdata  = VEC[i][6:5];
         init_done = VEC[i][4];
         tick();
         ps_wr = 1'b0; init_done = 1'b0;
         n_chk++;
         if ({pmc_img[1:0], dev_init, soft_rst_o} !== VEC[i][3:0]) begin
            n_bad++;
            $display("FAIL R2 R4 R5 R6 vector %0d: actual %b expected %b", i,
                     {pmc_img[1:0], dev_init, soft_rst_o}, VEC[i][3:0]);
         end
      end

      // R11 layout
      chk("R11 D0", pmc_img, 8'h08);
      wr_ps(2'b10);
      chk("R11 D2", pmc_img, 8'h0A);
      wr_ps(2'b00);

      // R8 system reset from D3hot with no-soft-reset set
      wr_ps(2'b11);
      pulse_sys();
      chk("R8 state", pmc_img[1:0], 2'b00);
      chk("R8 init", dev_init, 1'b0);
      chk("R8 nsr kept", pmc_img[3], 1'b1);

      // R3 R6 R7 soft reset path
      load_cfg(16'h0000);
      pulse_init();
      chk("R6 init set", dev_init, 1'b1);
      wr_ps(2'b11);
      chk("R5 no pulse D0->D3", soft_rst_o, 1'b0);
      wr_ps(2'b11);
      chk("R5 no pulse D3->D3", soft_rst_o, 1'b0);
      wr_ps(2'b00);
      chk("R3 pulse start", soft_rst_o, 1'b1);
      chk("R3 init cleared", dev_init, 1'b0);
      plen = 1;
      ps_wr = 1'b1; ps_wdata = 2'b11; init_done = 1'b1;
      tick();
      ps_wr = 1'b0; init_done = 1'b0;
      chk("R7 write ignored", pmc_img[1:0], 2'b00);
      for (int k = 0; k < 20 && soft_rst_o; k++) begin
         plen++;
         tick();
      end
      chk("R3 pulse length", plen, 4);
      chk("R6 init_done during pulse", dev_init, 1'b0);
      pulse_init();
      chk("R6 init after pulse", dev_init, 1'b1);

      // R8 system reset cuts a pulse
      wr_ps(2'b11);
      wr_ps(2'b00);
      chk("R3 second pulse", soft_rst_o, 1'b1);
      pulse_sys();
      chk("R8 pulse cut", soft_rst_o, 1'b0);
      chk("R8 init", dev_init, 1'b0);
      tick();
      chk("R8 pulse stays off", soft_rst_o, 1'b0);

      // R9 R12 PME context
      pme_cap = 1'b1;
      pme_en_wr = 1'b1; pme_en_wdata = 1'b1; tick(); pme_en_wr = 1'b0;
      pme_sts_set = 1'b1; tick(); pme_sts_set = 1'b0;
      chk("R9 pme set", {pmc_img[4], pmc_img[2]}, 2'b11);
      wr_ps(2'b11);
      wr_ps(2'b00);
      repeat (5) tick();
      chk("R12 soft reset keeps pme", {pmc_img[4], pmc_img[2]}, 2'b11);
      pulse_sys();
      chk("R9 sys keep", {pmc_img[4], pmc_img[2]}, 2'b11);
      pme_en_wr = 1'b1; pme_en_wdata = 1'b0; tick(); pme_en_wr = 1'b0;
      pulse_sys();
      chk("R9 sys drop", {pmc_img[4], pmc_img[2]}, 2'b00);
      pme_sts_set = 1'b1; tick(); pme_sts_set = 1'b0;
      pme_sts_clr = 1'b1; tick(); pme_sts_clr = 1'b0;
      chk("R9 status clear", pmc_img[4], 1'b0);
      pme_cap = 1'b0;
      pme_en_wr = 1'b1; pme_en_wdata = 1'b1; tick(); pme_en_wr = 1'b0;
      pme_sts_set = 1'b1; tick(); pme_sts_set = 1'b0;
      chk("R9 no cap", {pmc_img[4], pmc_img[2]}, 2'b00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule